// File: doc/BRIEF.md
# TDM Audio Slot Transmitter

This block serialises one stereo sample pair per frame onto a single data line. The bit clock and word clock arrive from outside and are sampled by the block's own system clock. A rising word clock, seen at a bit-clock rising edge, opens a frame. Each later bit-clock falling edge starts one bit position of that frame. The two sample words are sent MSB first in two slots. The output-enable marks the bit periods in which the line carries data and is meant to drive a tristate pad.

Slot placement comes from a primary offset, counted in bit clocks from the frame start. In shared mode the second slot follows the first directly. In split mode a separate 8-bit offset places the second slot that many bit clocks after the end of the first. Further controls can exchange the two channels, silence either channel or both, and release the line half a bit early at the end of each slot. All controls and both sample words are captured at the frame start, so changes made during a frame cannot disturb it.

Top module: `tdm_slot_tx`

## Requirements
- R1: After reset, `sdata` and `sdata_oe` are 0, and they stay 0 through any bit clocks until the first frame start.
- R2: A frame starts when `wclk`, sampled at a `bclk` rising edge, is 1 after having been 0 at the previous rising edge. The bit period that opens at the next `bclk` falling edge is position 0. The first slot occupies positions P to P+W-1, where P = `slot_ofs` (0..255) and W = SAMPLE_W.
- R3: With `split_mode` = 0, the second slot occupies positions P+W to P+2W-1.
- R4: With `split_mode` = 1, the second slot occupies positions P+W+S to P+2W+S-1, where S = `slot2_ofs` (0..255). The two slots never overlap.
- R5: Within a driven slot, bit k (k = 0 for the slot's first position) carries bit W-1-k of that slot's sample word, so the word goes out MSB first.
- R6: `sdata` and the rising edge of `sdata_oe` update only on the first system clock edge at which `bclk` is sampled low after being high. At that edge `sdata` takes the slot bit, or 0 where no enabled slot is being driven.
- R7: With `swap_en` = 0 the first slot carries `left_smp` and the second carries `right_smp`. With `swap_en` = 1 the first slot carries `right_smp` and the second carries `left_smp`.
- R8: `chan_en` encodes 0 = both channels on, 1 = left only, 2 = right only, 3 = both off. A slot whose channel is off keeps `sdata_oe` at 0 for all of its positions.
- R9: Outside both slots `sdata_oe` is 0. The position count saturates rather than wrapping, so a long gap without a frame start drives nothing. A new frame start restarts the count even if the previous frame is still sending.
- R10: With `early_hiz` = 0, `sdata_oe` stays 1 until the falling edge after a slot's last bit. With `early_hiz` = 1, it drops at the `bclk` rising edge inside each driven slot's last bit.
- R11: The control inputs and both sample words are captured at the frame start. Changes made at any other time do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples bclk and wclk |
| rst_n | input | 1 | Asynchronous reset, active low |
| bclk | input | 1 | Bit clock, synchronous to clk |
| wclk | input | 1 | Word clock; its rising edge marks a frame |
| left_smp | input | SAMPLE_W | Left sample word |
| right_smp | input | SAMPLE_W | Right sample word |
| slot_ofs | input | 8 | Primary offset P in bit clocks |
| slot2_ofs | input | 8 | Second-slot gap S used in split mode |
| split_mode | input | 1 | 1 = second slot placed by slot2_ofs |
| swap_en | input | 1 | 1 = exchange channels between slots |
| chan_en | input | 2 | Channel enable code |
| early_hiz | input | 1 | 1 = release the line half a bit early |
| sdata | output | 1 | Serial data |
| sdata_oe | output | 1 | Output enable for the data pad |

## Verification
On every cycle the assertions check the following. Data and the start of a drive appear only on bit-clock falling edges. A drive is released between falling edges only in early mode, at a slot's last bit. The captured controls and samples change only at a frame start. The two slots never overlap. A newly driven slot always belongs to an enabled channel. Other behaviour only shows against the bench's reference frames: exact slot positions for the shared and split offsets, including the 255 extremes; MSB-first order; swap; mid-frame control changes; frames restarted early; and saturation over long idle stretches.

// File: rtl/tdm_slot_pkg.sv
package tdm_slot_pkg;

  localparam int OFS_W = 8;

  localparam logic [1:0] EN_BOTH  = 2'd0;
  localparam logic [1:0] EN_LEFT  = 2'd1;
  localparam logic [1:0] EN_RIGHT = 2'd2;
  localparam logic [1:0] EN_NONE  = 2'd3;

  typedef struct packed {
    logic [OFS_W-1:0] ofs1;
    logic [OFS_W-1:0] ofs2;
    logic             split;
    logic             swap;
    logic [1:0]       en;
    logic             early;
  } tdm_ctrl_t;

  // start position of the second slot in bit clocks from frame start
  function automatic int slot2_base(tdm_ctrl_t c, int w);
    return int'(c.ofs1) + w + (c.split ? int'(c.ofs2) : 0);
  endfunction

  // whether the given channel side may drive under the enable code
  function automatic logic side_enabled(logic [1:0] en, logic right);
    if (right) return (en == EN_BOTH) || (en == EN_RIGHT);
    return (en == EN_BOTH) || (en == EN_LEFT);
  endfunction

endpackage

// File: rtl/tdm_edge_det.sv
module tdm_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic wclk,
  output logic bclk_rise,
  output logic bclk_fall,
  output logic frame_start
);
  logic bclk_q;
  logic wclk_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      wclk_s <= 1'b0;
    end else begin
      bclk_q <= bclk;
      if (bclk_rise) wclk_s <= wclk;
    end
  end

  assign bclk_rise   = bclk & ~bclk_q;
  assign bclk_fall   = ~bclk & bclk_q;
  assign frame_start = bclk_rise & wclk & ~wclk_s;

endmodule

// File: rtl/tdm_frame_ctl.sv
module tdm_frame_ctl
  import tdm_slot_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int POS_W    = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk_fall,
  input  logic                frame_start,
  input  tdm_ctrl_t           ctrl_in,
  input  logic [SAMPLE_W-1:0] left_in,
  input  logic [SAMPLE_W-1:0] right_in,
  output tdm_ctrl_t           ctrl_q,
  output logic [SAMPLE_W-1:0] left_q,
  output logic [SAMPLE_W-1:0] right_q,
  output logic [POS_W-1:0]    pos_nxt,
  output logic                active_nxt
);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [POS_W-1:0] pos;
  logic             active;
  logic             armed;

  // position of the bit period that the next falling edge opens
  always_comb begin
    pos_nxt    = pos;
    active_nxt = active;
    if (armed) begin
      pos_nxt    = '0;
      active_nxt = 1'b1;
    end else if (active && pos != POS_MAX) begin
      pos_nxt = pos + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      left_q  <= '0;
      right_q <= '0;
      pos     <= '0;
      active  <= 1'b0;
      armed   <= 1'b0;
    end else if (frame_start) begin
      ctrl_q  <= ctrl_in;
      left_q  <= left_in;
      right_q <= right_in;
      armed   <= 1'b1;
    end else if (bclk_fall) begin
      pos    <= pos_nxt;
      active <= active_nxt;
      armed  <= 1'b0;
    end
  end

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_start) |-> ($stable(ctrl_q) && $stable(left_q) && $stable(right_q))); // R11

endmodule

// File: rtl/tdm_slot_map.sv
module tdm_slot_map
  import tdm_slot_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int POS_W    = 10
) (
  input  logic [POS_W-1:0]    pos,
  input  logic                active,
  input  tdm_ctrl_t           ctrl,
  input  logic [SAMPLE_W-1:0] left_w,
  input  logic [SAMPLE_W-1:0] right_w,
  output logic                hit1,
  output logic                hit2,
  output logic                right_sel,
  output logic                drive,
  output logic                bit_val,
  output logic                last_bit
);
  localparam int IDX_W = $clog2(SAMPLE_W);

  logic [IDX_W-1:0] idx;

  always_comb begin
    int p;
    int s1;
    int s2;
    int k;
    p  = int'(pos);
    s1 = int'(ctrl.ofs1);
    s2 = slot2_base(ctrl, SAMPLE_W);
    hit1 = active && (p >= s1) && (p < s1 + SAMPLE_W);
    hit2 = active && (p >= s2) && (p < s2 + SAMPLE_W);
    right_sel = hit2 ? ~ctrl.swap : ctrl.swap;
    k = hit2 ? (p - s2) : (p - s1);
    idx = (hit1 || hit2) ? IDX_W'(SAMPLE_W - 1 - k) : '0;
    bit_val  = right_sel ? right_w[idx] : left_w[idx];
    drive    = (hit1 || hit2) && side_enabled(ctrl.en, right_sel);
    last_bit = (hit1 || hit2) && (k == SAMPLE_W - 1);
  end

endmodule

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx
  import tdm_slot_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk,
  input  logic                wclk,
  input  logic [SAMPLE_W-1:0] left_smp,
  input  logic [SAMPLE_W-1:0] right_smp,
  input  logic [OFS_W-1:0]    slot_ofs,
  input  logic [OFS_W-1:0]    slot2_ofs,
  input  logic                split_mode,
  input  logic                swap_en,
  input  logic [1:0]          chan_en,
  input  logic                early_hiz,
  output logic                sdata,
  output logic                sdata_oe
);
  localparam int POS_W = $clog2(2 * (1 << OFS_W) + 2 * SAMPLE_W + 1);

  // named events for assertions
  logic bclk_rise;
  logic bclk_fall;
  logic frame_start;

  tdm_ctrl_t           ctrl_in;
  tdm_ctrl_t           ctrl_q;
  logic [SAMPLE_W-1:0] left_q;
  logic [SAMPLE_W-1:0] right_q;
  logic [POS_W-1:0]    pos_nxt;
  logic                active_nxt;

  logic hit1_n, hit2_n, right_n, drv_n, bit_n, last_n;
  logic last_q;
  logic chan_right_q;

  assign ctrl_in = '{ofs1: slot_ofs, ofs2: slot2_ofs, split: split_mode,
                     swap: swap_en, en: chan_en, early: early_hiz};

  tdm_edge_det u_edge (
    .clk         (clk),
    .rst_n       (rst_n),
    .bclk        (bclk),
    .wclk        (wclk),
    .bclk_rise   (bclk_rise),
    .bclk_fall   (bclk_fall),
    .frame_start (frame_start)
  );

  tdm_frame_ctl #(.SAMPLE_W(SAMPLE_W), .POS_W(POS_W)) u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .bclk_fall   (bclk_fall),
    .frame_start (frame_start),
    .ctrl_in     (ctrl_in),
    .left_in     (left_smp),
    .right_in    (right_smp),
    .ctrl_q      (ctrl_q),
    .left_q      (left_q),
    .right_q     (right_q),
    .pos_nxt     (pos_nxt),
    .active_nxt  (active_nxt)
  );

  tdm_slot_map #(.SAMPLE_W(SAMPLE_W), .POS_W(POS_W)) u_map (
    .pos       (pos_nxt),
    .active    (active_nxt),
    .ctrl      (ctrl_q),
    .left_w    (left_q),
    .right_w   (right_q),
    .hit1      (hit1_n),
    .hit2      (hit2_n),
    .right_sel (right_n),
    .drive     (drv_n),
    .bit_val   (bit_n),
    .last_bit  (last_n)
  );

  // output stage: launch on falling edges, optional early release on rising
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdata        <= 1'b0;
      sdata_oe     <= 1'b0;
      last_q       <= 1'b0;
      chan_right_q <= 1'b0;
    end else if (bclk_fall) begin
      sdata        <= drv_n ? bit_n : 1'b0;
      sdata_oe     <= drv_n;
      last_q       <= drv_n & last_n;
      chan_right_q <= right_n;
    end else if (bclk_rise && ctrl_q.early && last_q) begin
      sdata_oe <= 1'b0;
    end
  end

  AST_OE_RISE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdata_oe) |-> $past(bclk_fall)); // R6

  AST_SD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bclk_fall) |-> $stable(sdata)); // R6

  AST_EARLY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sdata_oe) && !$past(bclk_fall)) |-> ($past(ctrl_q.early) && $past(last_q))); // R10

  AST_SLOTS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit1_n && hit2_n)); // R4

  AST_ENABLED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdata_oe) |-> side_enabled(ctrl_q.en, chan_right_q)); // R8

endmodule

// File: tb/sim_tdm_slot_tx.sv
module sim_tdm_slot_tx;
  localparam int W = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n = 1'b0;
  logic         bclk = 1'b0;
  logic         wclk = 1'b0;
  logic [W-1:0] left_smp = '0;
  logic [W-1:0] right_smp = '0;
  logic [7:0]   slot_ofs = '0;
  logic [7:0]   slot2_ofs = '0;
  logic         split_mode = 1'b0;
  logic         swap_en = 1'b0;
  logic [1:0]   chan_en = 2'd0;
  logic         early_hiz = 1'b0;
  logic         sdata;
  logic         sdata_oe;

  tdm_slot_tx #(.SAMPLE_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .wclk(wclk),
    .left_smp(left_smp), .right_smp(right_smp),
    .slot_ofs(slot_ofs), .slot2_ofs(slot2_ofs),
    .split_mode(split_mode), .swap_en(swap_en),
    .chan_en(chan_en), .early_hiz(early_hiz),
    .sdata(sdata), .sdata_oe(sdata_oe)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  string req = "R1";

  // reference model state
  int       m_pos = 0;
  bit       m_active = 0, m_pend = 0, m_wprev = 0;
  int       l_o1 = 0, l_o2 = 0, l_en = 0;
  bit       l_split = 0, l_swap = 0, l_early = 0;
  bit [W-1:0] l_left = '0, l_right = '0;
  bit       exp_oe = 0, exp_sd = 0;

  function automatic void eval(input int p, output bit drv, output bit bv, output bit last);
    int s1, s2, k;
    bit rt, hit;
    s1 = l_o1;
    s2 = l_split ? (l_o1 + W + l_o2) : (l_o1 + W);
    hit = 0; rt = 0; k = 0;
    if (p >= s1 && p < s1 + W) begin hit = 1; rt = l_swap; k = p - s1; end
    else if (p >= s2 && p < s2 + W) begin hit = 1; rt = !l_swap; k = p - s2; end
    drv  = hit && (l_en == 0 || (rt ? l_en == 2 : l_en == 1));
    bv   = drv ? (rt ? l_right[W-1-k] : l_left[W-1-k]) : 1'b0;
    last = hit && (k == W - 1);
  endfunction

  function automatic void model_fall();
    bit d, b, l;
    if (m_pend) begin m_pos = 0; m_active = 1; m_pend = 0; end
    else if (m_active) m_pos++;
    if (m_active) eval(m_pos, d, b, l); else begin d = 0; b = 0; end
    exp_oe = d;
    exp_sd = b;
  endfunction

  function automatic void model_rise();
    bit d, b, l;
    if (m_active && l_early && exp_oe) begin
      eval(m_pos, d, b, l);
      if (l) exp_oe = 0;
    end
    if (wclk && !m_wprev) begin
      l_o1 = slot_ofs; l_o2 = slot2_ofs; l_split = split_mode;
      l_swap = swap_en; l_en = chan_en; l_early = early_hiz;
      l_left = left_smp; l_right = right_smp;
      m_pend = 1;
    end
    m_wprev = wclk;
  endfunction

  task automatic compare();
    checks++;
    if (sdata_oe !== exp_oe || sdata !== exp_sd) begin
      fails++;
      $display("FAIL %s: oe=%0b sd=%0b expected oe=%0b sd=%0b at %0t",
               req, sdata_oe, sdata, exp_oe, exp_sd, $time);
    end
  endtask

  task automatic bit_period(input bit wc);
    @(negedge clk); compare(); wclk = wc; bclk = 1'b0; model_fall();
    @(negedge clk); compare(); bclk = 1'b1; model_rise();
    @(negedge clk); compare();
  endtask

  task automatic apply_alt();
    left_smp = ~left_smp;
    swap_en = ~swap_en;
    slot_ofs = slot_ofs + 8'd2;
    chan_en = 2'd3;
    early_hiz = 1'b1;
  endtask

  task automatic run_frame(input int nbits, input int chg_at);
    for (int i = 0; i < nbits; i++) begin
      if (i == chg_at) apply_alt();
      bit_period(i == 0);
    end
  endtask

  task automatic cfg(input int o1, input int o2, input bit sp, input bit sw,
                     input int en, input bit ea, input logic [W-1:0] l, input logic [W-1:0] r);
    slot_ofs = 8'(o1); slot2_ofs = 8'(o2); split_mode = sp; swap_en = sw;
    chan_en = 2'(en); early_hiz = ea; left_smp = l; right_smp = r;
  endtask

  function automatic int flen(input int o1, input int o2, input bit sp);
    return 1 + o1 + 2 * W + (sp ? o2 : 0) + 3;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs low in reset
    checks++;
    if (sdata_oe !== 1'b0 || sdata !== 1'b0) begin
      fails++;
      $display("FAIL R1: oe=%0b sd=%0b expected oe=0 sd=0", sdata_oe, sdata);
    end
    rst_n = 1'b1;
    req = "R1";
    for (int i = 0; i < 6; i++) bit_period(1'b0);

    req = "R2 R3 R5 R6";
    cfg(0, 0, 0, 0, 0, 0, 16'hA5C3, 16'h0F0F);
    run_frame(flen(0, 0, 0), -1);

    req = "R2 R7";
    cfg(5, 9, 0, 1, 0, 0, 16'h8001, 16'h7FFE);
    run_frame(flen(5, 9, 0), -1);

    req = "R4 R8";
    cfg(3, 7, 1, 0, 1, 0, 16'h1234, 16'hFEDC);
    run_frame(flen(3, 7, 1), -1);

    req = "R4 R8 R10";
    cfg(2, 0, 1, 1, 2, 1, 16'hC0DE, 16'hBEEF);
    run_frame(flen(2, 0, 1), -1);

    req = "R8 R10";
    cfg(1, 4, 1, 0, 3, 1, 16'hFFFF, 16'hFFFF);
    run_frame(flen(1, 4, 1), -1);

    req = "R10";
    cfg(4, 3, 1, 0, 0, 1, 16'hFFFF, 16'h5555);
    run_frame(flen(4, 3, 1), -1);

    req = "R2 R4";
    cfg(255, 255, 1, 0, 0, 0, 16'h9ABC, 16'h3C3C);
    run_frame(flen(255, 255, 1), -1);

    req = "R11";
    cfg(6, 2, 1, 0, 0, 0, 16'h6B2D, 16'hD2B6);
    run_frame(flen(6, 2, 1), 3);
    run_frame(20, 12);

    req = "R9";
    cfg(0, 0, 0, 0, 0, 0, 16'hAAAA, 16'h5555);
    run_frame(10, -1);
    run_frame(1100, -1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule